// File: doc/BRIEF.md
# Asynchronous SRAM Port Controller

This block connects an on-chip bus master to an external static RAM of 512K words by 32 bits that has no clock. A request carries a 19-bit word address, a write flag, 32 bits of write data and a four-bit lane mask. The master offers it with a valid/ready handshake. The controller turns each request into one complete memory cycle on the active-low select, output-enable, write-enable and per-lane enable pins. A read returns its data together with a single-cycle done pulse. A write also ends with that pulse.

Every phase of a memory cycle lasts a whole number of clock cycles, set by a parameter. These phases are address set-up, access time, write pulse, data hold, bus turnaround and the start-up wait. The defaults suit a 100 MHz clock and the fastest grade of memory. The shared data pins are split into an output word, a drive enable and an input word, so that the pad ring can build the tri-state buffer.

After reset the controller waits a fixed number of cycles before it accepts any request, so the memory has time to come up. A write can start with write enable falling. It is always ended by write enable rising while the chip select is still low. The controller drives the data bus before that rising edge and keeps driving it for the hold phase after it.

Top module: `asram_port_ctrl`

## Requirements
- R1: After reset is released, req_ready stays low and mem_ce_n, mem_oe_n and mem_we_n stay high for exactly PWRUP_CYC clock cycles. After that, req_ready goes high.
- R2: When no access is in progress (reset, power-up wait, idle, turnaround), mem_ce_n, mem_oe_n and mem_we_n are high, mem_be_n is 4'b1111 and mem_dq_oe is low.
- R3: A read drives mem_ce_n low, mem_oe_n low and mem_we_n high. It drives mem_addr with the request address and mem_be_n with the inverted mask. Mask bit i selects lane i, which is data bits 8i+7:8i.
- R4: A read's done pulse arrives RD_ACC_CYC+1 clock edges after the accepting edge. rsp_rdata then holds the memory word on the lanes the mask selects, and zero on the other lanes.
- R5: A write drives mem_ce_n low and mem_oe_n high. mem_we_n is low for exactly WR_PULSE_CYC cycles, and only while mem_ce_n is low. Only the selected lanes of the addressed word are changed.
- R6: mem_dq_oe is never high while mem_oe_n is low. Whenever mem_we_n is low, mem_dq_oe is high and mem_dq_out carries the write data. mem_dq_oe is still high in the cycle after mem_we_n rises.
- R7: A write that does not follow a read gives its done pulse WR_SETUP_CYC+WR_PULSE_CYC+WR_HOLD_CYC clock edges after the accepting edge.
- R8: A write accepted right after a read first spends TURN_CYC cycles with every strobe high and the bus undriven, so its done pulse is TURN_CYC edges later than in R7.
- R9: req_ready is high only in idle, and a request is accepted only on an edge where req_valid and req_ready are both high. A request offered while an access is busy is ignored. rsp_done is high for one cycle per access.
- R10: mem_addr and mem_be_n do not change while mem_ce_n stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Word address |
| req_wdata | input | 32 | Write data |
| req_mask | input | 4 | Lane select, bit i = data bits 8i+7:8i |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Read data, unselected lanes zero |
| mem_addr | output | 19 | Memory word address |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_be_n | output | 4 | Lane enables, active low |
| mem_dq_out | output | 32 | Data toward the memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |
| mem_dq_in | input | 32 | Data from the memory |

## Verification
The embedded assertions check several rules on every cycle. The bus is never driven while the memory's outputs are enabled. Write enable low always comes with chip select low and the bus driven. The drivers stay on for the cycle after write enable rises. Address and lane enables hold still across a select window. Done is never two cycles long. Other properties are visible only through the bench's scenarios. These are the length of the start-up wait, the exact latency of reads, writes and writes after reads, whether the right lanes were stored or zeroed, and the fact that a request offered while the controller is busy leaves no trace in memory.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    ST_PWRUP,
    ST_IDLE,
    ST_RD_SETUP,
    ST_RD_SAMPLE,
    ST_WR_SETUP,
    ST_WR_PULSE,
    ST_WR_RECOVER,
    ST_TURN
  } asram_state_e;

endpackage

// File: rtl/asram_delay_cnt.sv
module asram_delay_cnt #(
  parameter int CNT_W     = 8,
  parameter int RESET_VAL = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)
      cnt_d = load_val;
    else if (cnt_q != '0)
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= CNT_W'(RESET_VAL);
    else
      cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/asram_lanes.sv
module asram_lanes #(
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  localparam int DW    = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_en,
  input  logic             drive_en,
  input  logic [LANES-1:0] lane_sel,
  input  logic [DW-1:0]    wdata,
  input  logic [DW-1:0]    dq_in,
  output logic [DW-1:0]    dq_out,
  output logic             dq_oe,
  output logic [DW-1:0]    rdata
);

  assign dq_out = wdata;
  assign dq_oe  = drive_en;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] lane_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        lane_q <= '0;
      else if (cap_en)
        lane_q <= lane_sel[g] ? dq_in[g*LANE_W +: LANE_W] : '0;
    end

    assign rdata[g*LANE_W +: LANE_W] = lane_q;

    // R4
    unsel_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_en && !lane_sel[g]) |=> (rdata[g*LANE_W +: LANE_W] == '0));
  end

endmodule

// File: rtl/asram_port_ctrl.sv
module asram_port_ctrl
  import asram_pkg::*;
#(
  parameter int AW           = 19,
  parameter int LANES        = 4,
  parameter int LANE_W       = 8,
  parameter int PWRUP_CYC    = 100000,
  parameter int RD_ACC_CYC   = 1,
  parameter int WR_SETUP_CYC = 1,
  parameter int WR_PULSE_CYC = 1,
  parameter int WR_HOLD_CYC  = 1,
  parameter int TURN_CYC     = 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic                     req_write,
  input  logic [AW-1:0]            req_addr,
  input  logic [LANES*LANE_W-1:0]  req_wdata,
  input  logic [LANES-1:0]         req_mask,
  output logic                     rsp_done,
  output logic [LANES*LANE_W-1:0]  rsp_rdata,
  output logic [AW-1:0]            mem_addr,
  output logic                     mem_ce_n,
  output logic                     mem_oe_n,
  output logic                     mem_we_n,
  output logic [LANES-1:0]         mem_be_n,
  output logic [LANES*LANE_W-1:0]  mem_dq_out,
  output logic                     mem_dq_oe,
  input  logic [LANES*LANE_W-1:0]  mem_dq_in
);

  localparam int DW     = LANES * LANE_W;
  localparam int M1     = (RD_ACC_CYC > WR_SETUP_CYC) ? RD_ACC_CYC : WR_SETUP_CYC;
  localparam int M2     = (WR_PULSE_CYC > WR_HOLD_CYC) ? WR_PULSE_CYC : WR_HOLD_CYC;
  localparam int M3     = (M1 > M2) ? M1 : M2;
  localparam int M4     = (M3 > TURN_CYC) ? M3 : TURN_CYC;
  localparam int MAXLEN = (M4 > PWRUP_CYC) ? M4 : PWRUP_CYC;
  localparam int CNT_W  = $clog2(MAXLEN + 1);

  asram_state_e        state_q, state_d;
  logic [AW-1:0]       addr_q;
  logic [DW-1:0]       wdata_q;
  logic [LANES-1:0]    mask_q;
  logic                last_rd_q, last_rd_d;
  logic                done_q, done_d;
  logic                accept;
  logic                expired;
  logic                cnt_load;
  logic [CNT_W-1:0]    cnt_val;
  logic                in_read, in_write_bus, active;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;

  // Next-state logic
  always_comb begin
    state_d   = state_q;
    last_rd_d = last_rd_q;
    done_d    = 1'b0;
    unique case (state_q)
      ST_PWRUP:      if (expired) state_d = ST_IDLE;
      ST_IDLE:
        if (accept) begin
          if (!req_write)    state_d = ST_RD_SETUP;
          else if (last_rd_q) state_d = ST_TURN;
          else               state_d = ST_WR_SETUP;
          last_rd_d = !req_write;
        end
      ST_RD_SETUP:   if (expired) state_d = ST_RD_SAMPLE;
      ST_RD_SAMPLE:  begin state_d = ST_IDLE; done_d = 1'b1; end
      ST_TURN:       if (expired) state_d = ST_WR_SETUP;
      ST_WR_SETUP:   if (expired) state_d = ST_WR_PULSE;
      ST_WR_PULSE:   if (expired) state_d = ST_WR_RECOVER;
      ST_WR_RECOVER: if (expired) begin state_d = ST_IDLE; done_d = 1'b1; end
      default:       state_d = ST_IDLE;
    endcase
  end

  // Phase length loaded on every state change
  always_comb begin
    cnt_load = (state_d != state_q);
    unique case (state_d)
      ST_RD_SETUP:   cnt_val = CNT_W'(RD_ACC_CYC - 1);
      ST_TURN:       cnt_val = CNT_W'(TURN_CYC - 1);
      ST_WR_SETUP:   cnt_val = CNT_W'(WR_SETUP_CYC - 1);
      ST_WR_PULSE:   cnt_val = CNT_W'(WR_PULSE_CYC - 1);
      ST_WR_RECOVER: cnt_val = CNT_W'(WR_HOLD_CYC - 1);
      default:       cnt_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_PWRUP;
      last_rd_q <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      state_q   <= state_d;
      last_rd_q <= last_rd_d;
      done_q    <= done_d;
    end
  end

  // Request capture, enabled only on acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      mask_q  <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      mask_q  <= req_mask;
    end
  end

  asram_delay_cnt #(
    .CNT_W     (CNT_W),
    .RESET_VAL (PWRUP_CYC - 1)
  ) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cnt_load),
    .load_val (cnt_val),
    .expired  (expired)
  );

  // Strobe decode
  assign in_read      = (state_q == ST_RD_SETUP) || (state_q == ST_RD_SAMPLE);
  assign in_write_bus = (state_q == ST_WR_PULSE) || (state_q == ST_WR_RECOVER);
  assign active       = in_read || in_write_bus || (state_q == ST_WR_SETUP);

  assign mem_addr = addr_q;
  assign mem_ce_n = !active;
  assign mem_oe_n = !in_read;
  assign mem_we_n = (state_q != ST_WR_PULSE);
  assign mem_be_n = active ? ~mask_q : '1;
  assign rsp_done = done_q;

  asram_lanes #(
    .LANES  (LANES),
    .LANE_W (LANE_W)
  ) u_lanes (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_en   (state_q == ST_RD_SAMPLE),
    .drive_en (in_write_bus),
    .lane_sel (mask_q),
    .wdata    (wdata_q),
    .dq_in    (mem_dq_in),
    .dq_out   (mem_dq_out),
    .dq_oe    (mem_dq_oe),
    .rdata    (rsp_rdata)
  );

  // R1
  pwrup_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PWRUP) |-> (mem_ce_n && mem_we_n && mem_oe_n && !req_ready));
  // R6
  no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_dq_oe && !mem_oe_n));
  // R6
  we_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_dq_oe);
  // R6
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> mem_dq_oe);
  // R5
  we_in_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_ce_n && mem_oe_n));
  // R10
  addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> ($stable(mem_addr) && $stable(mem_be_n)));
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);
  // R9
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

endmodule

// File: tb/asram_port_ctrl_tb.sv
module asram_port_ctrl_tb;

  localparam int CLK_NS = 10;
  localparam int P_PWR  = 20;
  localparam int P_RD   = 2;
  localparam int P_WS   = 1;
  localparam int P_WP   = 2;
  localparam int P_WH   = 1;
  localparam int P_TA   = 1;

  logic        clk, rst_n;
  logic        req_valid, req_ready, req_write;
  logic [18:0] req_addr;
  logic [31:0] req_wdata;
  logic [3:0]  req_mask;
  logic        rsp_done;
  logic [31:0] rsp_rdata;
  logic [18:0] mem_addr;
  logic        mem_ce_n, mem_oe_n, mem_we_n;
  logic [3:0]  mem_be_n;
  logic [31:0] mem_dq_out;
  logic        mem_dq_oe;
  logic [31:0] mem_dq_in;

  asram_port_ctrl #(
    .PWRUP_CYC(P_PWR), .RD_ACC_CYC(P_RD), .WR_SETUP_CYC(P_WS),
    .WR_PULSE_CYC(P_WP), .WR_HOLD_CYC(P_WH), .TURN_CYC(P_TA)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_mask(req_mask), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_be_n(mem_be_n), .mem_dq_out(mem_dq_out),
    .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  initial clk = 1'b0;
  always #(CLK_NS/2) clk = ~clk;

  // Behavioural memory: 16 words indexed by the low address bits
  logic [31:0] mdl [16];

  always @(posedge mem_we_n) begin
    if (mem_ce_n === 1'b0 && mem_dq_oe === 1'b1) begin
      for (int i = 0; i < 4; i++)
        if (!mem_be_n[i]) mdl[mem_addr[3:0]][i*8 +: 8] <= mem_dq_out[i*8 +: 8];
    end
  end

  always_comb begin
    for (int i = 0; i < 4; i++)
      mem_dq_in[i*8 +: 8] = (!mem_ce_n && !mem_oe_n && mem_we_n && !mem_be_n[i])
                            ? mdl[mem_addr[3:0]][i*8 +: 8] : 8'hDE;
  end

  int n_chk  = 0;
  int n_fail = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic        wr;
    logic [18:0] addr;
    logic [31:0] wdata;
    logic [3:0]  mask;
    logic [31:0] exp;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{1'b1, 19'h40003, 32'h11223344, 4'b1111, 32'h0},
    '{1'b0, 19'h40003, 32'h0,        4'b1111, 32'h11223344},
    '{1'b1, 19'h40003, 32'hAABBCCDD, 4'b0101, 32'h0},
    '{1'b0, 19'h40003, 32'h0,        4'b1111, 32'h11BB33DD},
    '{1'b0, 19'h40003, 32'h0,        4'b1000, 32'h11000000},
    '{1'b1, 19'h7FFFF, 32'hCAFEF00D, 4'b1010, 32'h0},
    '{1'b0, 19'h7FFFF, 32'h0,        4'b1111, 32'hCA00F000},
    '{1'b0, 19'h00005, 32'h0,        4'b0011, 32'h00000000}
  };

  // Results of the last request
  int          r_lat, r_we_cyc;
  bit          r_drv_ok, r_rdy_ok, r_strb_ok, r_seen;
  logic [31:0] r_data;

  // Issue one request and follow it to its done pulse
  task automatic run_req(input logic wr, input logic [18:0] a,
                         input logic [31:0] d, input logic [3:0] m);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    r_lat = 0; r_we_cyc = 0; r_drv_ok = 1; r_rdy_ok = 1; r_strb_ok = 1; r_seen = 0;
    while (!rsp_done && r_lat < 100) begin
      if (req_ready) r_rdy_ok = 0;
      if (!mem_ce_n && !r_seen) begin
        r_seen = 1;
        if (mem_addr != a || mem_be_n != ~m) r_strb_ok = 0;
        if (!wr && (mem_oe_n || !mem_we_n)) r_strb_ok = 0;
        if (wr && !mem_oe_n) r_strb_ok = 0;
      end
      if (!mem_we_n) begin
        r_we_cyc++;
        if (!(mem_dq_oe && mem_dq_out == d && mem_oe_n && !mem_ce_n)) r_drv_ok = 0;
      end
      if (mem_dq_oe && !mem_oe_n) r_drv_ok = 0;
      @(posedge clk);
      r_lat++;
      @(negedge clk);
    end
    r_data = rsp_rdata;
  endtask

  initial begin
    #(CLK_NS * 20000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    bit prev_rd;
    bit quiet;
    int n;
    int exp_lat;
    for (int i = 0; i < 16; i++) mdl[i] = 32'h0;
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    req_addr = '0; req_wdata = '0; req_mask = '0;
    repeat (3) @(negedge clk);

    // R2: reset state
    check(!req_ready && mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe && mem_be_n == 4'hF,
          "R2 reset strobes", {27'b0, req_ready, mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe},
          {27'b0, 5'b01110});

    // R1: power-up wait length and quiet strobes
    rst_n = 1'b1;
    n = 0; quiet = 1;
    while (!req_ready && n < 1000) begin
      if (!(mem_ce_n && mem_oe_n && mem_we_n)) quiet = 0;
      @(posedge clk); n++; @(negedge clk);
    end
    check(n == P_PWR, "R1 power-up cycles", n, P_PWR);
    check(quiet, "R1 strobes quiet during wait", {31'b0, quiet}, 32'h1);
    // R2: idle state after wait
    check(mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe && mem_be_n == 4'hF,
          "R2 idle strobes", {28'b0, mem_be_n}, 32'hF);

    // Vector table
    prev_rd = 0;
    for (int v = 0; v < 8; v++) begin
      run_req(VEC[v].wr, VEC[v].addr, VEC[v].wdata, VEC[v].mask);
      if (VEC[v].wr) begin
        exp_lat = P_WS + P_WP + P_WH + (prev_rd ? P_TA : 0);
        // R7 / R8: write latency
        check(r_lat == exp_lat, prev_rd ? "R8 write-after-read latency" : "R7 write latency",
              r_lat, exp_lat);
        // R5: pulse width
        check(r_we_cyc == P_WP, "R5 write pulse cycles", r_we_cyc, P_WP);
      end else begin
        exp_lat = P_RD + 1;
        // R4: read latency and data
        check(r_lat == exp_lat, "R4 read latency", r_lat, exp_lat);
        check(r_data == VEC[v].exp, "R4 read data", r_data, VEC[v].exp);
        check(r_we_cyc == 0, "R3 no write strobe in read", r_we_cyc, 0);
      end
      check(r_seen && r_strb_ok, "R3 R5 R10 access strobes", {31'b0, r_strb_ok}, 32'h1);
      check(r_drv_ok, "R6 data drivers", {31'b0, r_drv_ok}, 32'h1);
      check(r_rdy_ok, "R9 ready low while busy", {31'b0, r_rdy_ok}, 32'h1);
      @(posedge clk); @(negedge clk);
      // R9: done is a single pulse; R2: idle afterwards
      check(!rsp_done, "R9 done one cycle", {31'b0, rsp_done}, 32'h0);
      check(mem_ce_n && !mem_dq_oe && mem_be_n == 4'hF, "R2 idle between accesses",
            {28'b0, mem_be_n}, 32'hF);
      prev_rd = !VEC[v].wr;
    end

    // R9: request offered while busy is ignored
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 19'h40003; req_mask = 4'hF;
    @(posedge clk); @(negedge clk);
    req_write = 1'b1; req_addr = 19'h7FFFF; req_wdata = 32'hFFFFFFFF; req_mask = 4'hF;
    check(!req_ready, "R9 ready low during access", {31'b0, req_ready}, 32'h0);
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    while (!rsp_done && n < 100) begin @(posedge clk); n++; @(negedge clk); end
    check(rsp_rdata == 32'h11BB33DD, "R9 busy read result", rsp_rdata, 32'h11BB33DD);
    n = 0;
    for (int k = 0; k < 8; k++) begin
      @(posedge clk); @(negedge clk);
      if (!mem_ce_n || rsp_done) n++;
    end
    check(n == 0, "R9 no access from ignored request", n, 0);
    run_req(1'b0, 19'h7FFFF, 32'h0, 4'hF);
    check(r_data == 32'hCA00F000, "R9 ignored write left memory intact", r_data, 32'hCA00F000);

    // R5: lanes outside the mask untouched in the model after a partial write
    run_req(1'b1, 19'h00005, 32'h99887766, 4'b0010);
    run_req(1'b0, 19'h00005, 32'h0, 4'b1111);
    check(r_data == 32'h00007700, "R5 single-lane write", r_data, 32'h00007700);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule